// File: doc/BRIEF.md
# Hierarchical SMI Status Aggregator

This block gathers system management interrupt requests from a dozen sources into one 16-bit top-level status word and raises a single request line, `smi_req`, while any bit of that word is set. The word holds two kinds of bit. Some are latched directly in the word and are cleared by a read strobe on the status port. The others are summary bits. Each shows the OR of a second-level status register kept inside the block. A status read leaves them alone, and they fall only after their second-level bits are cleared by writing ones.

The register interface is a plain strobe bus with no back-pressure. A read or write strobe is accepted in the cycle it is high, and the block is always ready. `stat_rdata` always shows the current word, and a `stat_rd` pulse clears the clear-on-read bits at the end of that cycle. `l2_sel` picks one of the four second-level registers, `l2_rdata` shows its contents, and `l2_wr` clears it with a write-one-to-clear mask. Event inputs are single-cycle pulses. The external SMI lines are active-low, asynchronous pins: they are synchronised inside the block and trigger on falling edges.

Top module: `smi_status_hub`

## Requirements
- R1: After reset, the status word, `smi_req`, all four second-level registers and all three enable bits are 0.
- R2: The clear-on-read bits are bit 12 (NMI), bit 11 (peripheral I/O interrupt), bit 8 (software), bit 7 (A20 toggle), bit 6 (video timer) and bit 5 (video retrace). Each is set in the cycle after its event pulse, and it is cleared in the cycle after a `stat_rd` strobe.
- R3: The status word can be read in the same cycle that an event arrives. That read returns the old value, and the bit for the new event is set afterwards. This holds even when the event's bit is one of the bits being cleared.
- R4: A write on `cfg_wr` loads the enables from `cfg_wdata`: bit 0 enables A20, bit 1 enables the video timer and bit 2 enables video retrace. While its enable is 0, an event on one of these three sources leaves its status bit at 0.
- R5: Each bit of the 8-bit external second-level register (`l2_sel` = 0) is set by a falling edge on the matching `ext_smi_n` pin. It is set once per edge, after two synchroniser stages and one edge stage. A rising edge or a steady level sets nothing.
- R6: Four bits are summaries: bit 10 (external), bit 9 (timers/traps, `l2_sel` = 1), bit 3 (LPC, 2-bit, `l2_sel` = 2) and bit 2 (ACPI, `l2_sel` = 3). Each summary is the OR of its second-level register, registered one cycle. A status read does not clear it.
- R7: `l2_wr` clears the selected second-level register's bits where `l2_wdata` holds 1 and leaves the other bits unchanged. The summary bit drops one cycle after the last of its bits is cleared.
- R8: Bits 15:13, bit 4 and bits 1:0 of the status word always read 0.
- R9: `smi_req` is the OR of the status word registered one cycle. It falls one cycle after the word becomes zero.
- R10: An event that arrives in the same cycle as a write-one-to-clear of its own second-level bit leaves that bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_evt | input | 1 | NMI activity pulse |
| sio_irq_evt | input | 1 | Peripheral I/O block interrupt pulse |
| sw_evt | input | 1 | Software SMI pulse |
| a20_evt | input | 1 | A20 mask toggle request pulse |
| vtmr_evt | input | 1 | Video timer expiry pulse |
| vrtr_evt | input | 1 | Video retrace pulse |
| ext_smi_n | input | 8 | External active-low SMI pins |
| trap_evt | input | 8 | Timer expiry / I/O trap hit pulses |
| lpc_evt | input | 2 | LPC source pulses |
| acpi_evt | input | 8 | ACPI register access pulses |
| cfg_wr | input | 1 | Enable register write strobe |
| cfg_wdata | input | 3 | Enable values (bit0 A20, bit1 video timer, bit2 retrace) |
| stat_rd | input | 1 | Status read strobe (clears clear-on-read bits) |
| stat_rdata | output | 16 | Top-level status word |
| l2_sel | input | 2 | Second-level select: 0 ext, 1 timer/trap, 2 LPC, 3 ACPI |
| l2_wr | input | 1 | Second-level write-one-to-clear strobe |
| l2_wdata | input | 16 | Clear mask |
| l2_rdata | output | 16 | Selected second-level register, zero-extended |
| smi_req | output | 1 | SMI request |

## Verification
The bench targets four collisions:
- A read strobe in the same cycle as a new event. A design that clears before it merges would lose the event.
- A write-one-to-clear in the same cycle as an event on the bit being cleared. A design that gives the clear priority would drop the request.
- A status read while summary bits are set. A design that treats summaries like latched bits would wipe them, although their second-level bits are still pending.
- A held-low external pin and its rising edge. A level-sensitive design would set its bit again after the bit has been cleared.

The bench also checks that disabled sources are ignored, that reserved bits stay zero with every source active, and that the summary and request lag by exactly one cycle.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int unsigned STAT_W = 16;
  localparam int unsigned EN_W   = 3;
  localparam int unsigned B_NMI  = 12;
  localparam int unsigned B_SIO  = 11;
  localparam int unsigned B_EXT  = 10;
  localparam int unsigned B_TMR  = 9;
  localparam int unsigned B_SW   = 8;
  localparam int unsigned B_A20  = 7;
  localparam int unsigned B_VTMR = 6;
  localparam int unsigned B_VRTR = 5;
  localparam int unsigned B_LPC  = 3;
  localparam int unsigned B_ACPI = 2;
  localparam int unsigned N_COR  = 6;

  typedef enum logic [1:0] {
    L2_EXT  = 2'd0,
    L2_TMR  = 2'd1,
    L2_LPC  = 2'd2,
    L2_ACPI = 2'd3
  } l2_sel_e;

  typedef struct packed {
    logic vrtr;
    logic vtmr;
    logic a20;
  } smi_en_t;
endpackage

// File: rtl/smi_cor_bank.sv
module smi_cor_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         rd_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (rd_i ? '0 : stat_q) | set_i;
  end

  assign stat_o = stat_q;

  // R3
  cor_evt_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)));

  // R2
  cor_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && set_i == '0) |=> (stat_q == '0));
endmodule

// File: rtl/smi_fall_det.sv
module smi_fall_det #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_n_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] sync_q [STAGES];
  logic [W-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= '1;
          else        sync_q[0] <= pin_n_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= '1;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];

  // R5
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall_o & $past(fall_o)) == '0));
endmodule

// File: rtl/smi_w1c_reg.sv
module smi_w1c_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o,
  output logic         any_o
);
  logic [W-1:0] stat_q;
  logic         any_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      any_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_i) | evt_i;
      any_q  <= |stat_q;
    end
  end

  assign stat_o = stat_q;
  assign any_o  = any_q;

  // R10
  w1c_evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~evt_i) != '0) |=> ((stat_q & $past(clr_i & ~evt_i)) == '0));

  // R6
  w1c_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |=> !any_q);
endmodule

// File: rtl/smi_status_hub.sv
module smi_status_hub
  import smi_pkg::*;
#(
  parameter int unsigned EXT_W  = 8,
  parameter int unsigned TRAP_W = 8,
  parameter int unsigned LPC_W  = 2,
  parameter int unsigned ACPI_W = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 nmi_evt,
  input  logic                 sio_irq_evt,
  input  logic                 sw_evt,
  input  logic                 a20_evt,
  input  logic                 vtmr_evt,
  input  logic                 vrtr_evt,
  input  logic [EXT_W-1:0]     ext_smi_n,
  input  logic [TRAP_W-1:0]    trap_evt,
  input  logic [LPC_W-1:0]     lpc_evt,
  input  logic [ACPI_W-1:0]    acpi_evt,
  input  logic                 cfg_wr,
  input  logic [EN_W-1:0]      cfg_wdata,
  input  logic                 stat_rd,
  output logic [STAT_W-1:0]    stat_rdata,
  input  logic [1:0]           l2_sel,
  input  logic                 l2_wr,
  input  logic [STAT_W-1:0]    l2_wdata,
  output logic [STAT_W-1:0]    l2_rdata,
  output logic                 smi_req
);
  smi_en_t           en_q;
  logic [N_COR-1:0]  cor_set, cor_stat;
  logic [EXT_W-1:0]  ext_fall, ext_clr, ext_stat;
  logic [TRAP_W-1:0] trap_clr, trap_stat;
  logic [LPC_W-1:0]  lpc_clr, lpc_stat;
  logic [ACPI_W-1:0] acpi_clr, acpi_stat;
  logic              ext_any, trap_any, lpc_any, acpi_any;
  logic [STAT_W-1:0] stat_word;
  logic              req_q;
  l2_sel_e           sel;

  assign sel = l2_sel_e'(l2_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (cfg_wr) en_q <= smi_en_t'(cfg_wdata);
  end

  assign cor_set = {nmi_evt, sio_irq_evt, sw_evt,
                    a20_evt & en_q.a20, vtmr_evt & en_q.vtmr, vrtr_evt & en_q.vrtr};

  smi_cor_bank #(.N(N_COR)) u_cor (
    .clk(clk), .rst_n(rst_n), .set_i(cor_set), .rd_i(stat_rd), .stat_o(cor_stat)
  );

  smi_fall_det #(.W(EXT_W), .STAGES(SYNC_N)) u_fall (
    .clk(clk), .rst_n(rst_n), .pin_n_i(ext_smi_n), .fall_o(ext_fall)
  );

  assign ext_clr  = (l2_wr && sel == L2_EXT)  ? l2_wdata[EXT_W-1:0]  : '0;
  assign trap_clr = (l2_wr && sel == L2_TMR)  ? l2_wdata[TRAP_W-1:0] : '0;
  assign lpc_clr  = (l2_wr && sel == L2_LPC)  ? l2_wdata[LPC_W-1:0]  : '0;
  assign acpi_clr = (l2_wr && sel == L2_ACPI) ? l2_wdata[ACPI_W-1:0] : '0;

  smi_w1c_reg #(.W(EXT_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .evt_i(ext_fall), .clr_i(ext_clr),
    .stat_o(ext_stat), .any_o(ext_any)
  );
  smi_w1c_reg #(.W(TRAP_W)) u_trap (
    .clk(clk), .rst_n(rst_n), .evt_i(trap_evt), .clr_i(trap_clr),
    .stat_o(trap_stat), .any_o(trap_any)
  );
  smi_w1c_reg #(.W(LPC_W)) u_lpc (
    .clk(clk), .rst_n(rst_n), .evt_i(lpc_evt), .clr_i(lpc_clr),
    .stat_o(lpc_stat), .any_o(lpc_any)
  );
  smi_w1c_reg #(.W(ACPI_W)) u_acpi (
    .clk(clk), .rst_n(rst_n), .evt_i(acpi_evt), .clr_i(acpi_clr),
    .stat_o(acpi_stat), .any_o(acpi_any)
  );

  always_comb begin
    stat_word         = '0;
    stat_word[B_NMI]  = cor_stat[5];
    stat_word[B_SIO]  = cor_stat[4];
    stat_word[B_SW]   = cor_stat[3];
    stat_word[B_A20]  = cor_stat[2];
    stat_word[B_VTMR] = cor_stat[1];
    stat_word[B_VRTR] = cor_stat[0];
    stat_word[B_EXT]  = ext_any;
    stat_word[B_TMR]  = trap_any;
    stat_word[B_LPC]  = lpc_any;
    stat_word[B_ACPI] = acpi_any;
  end

  always_comb begin
    l2_rdata = '0;
    case (sel)
      L2_EXT:  l2_rdata[EXT_W-1:0]  = ext_stat;
      L2_TMR:  l2_rdata[TRAP_W-1:0] = trap_stat;
      L2_LPC:  l2_rdata[LPC_W-1:0]  = lpc_stat;
      default: l2_rdata[ACPI_W-1:0] = acpi_stat;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= |stat_word;
  end

  assign stat_rdata = stat_word;
  assign smi_req    = req_q;

  // R9
  req_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata == '0) |=> !smi_req);

  // R6
  summary_survives_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && ext_stat != '0) |=> stat_rdata[B_EXT]);

  // R4
  a20_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q.a20 && (stat_rd || !stat_rdata[B_A20])) |=> !stat_rdata[B_A20]);
endmodule

// File: tb/smi_status_hub_tb_top.sv
module smi_status_hub_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_evt = 0, sio_irq_evt = 0, sw_evt = 0, a20_evt = 0, vtmr_evt = 0, vrtr_evt = 0;
  logic [7:0]  ext_smi_n = 8'hFF;
  logic [7:0]  trap_evt = '0;
  logic [1:0]  lpc_evt = '0;
  logic [7:0]  acpi_evt = '0;
  logic        cfg_wr = 0;
  logic [2:0]  cfg_wdata = '0;
  logic        stat_rd = 0;
  logic [15:0] stat_rdata;
  logic [1:0]  l2_sel = '0;
  logic        l2_wr = 0;
  logic [15:0] l2_wdata = '0;
  logic [15:0] l2_rdata;
  logic        smi_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  smi_status_hub dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_evt(nmi_evt), .sio_irq_evt(sio_irq_evt),
    .sw_evt(sw_evt), .a20_evt(a20_evt), .vtmr_evt(vtmr_evt), .vrtr_evt(vrtr_evt),
    .ext_smi_n(ext_smi_n), .trap_evt(trap_evt), .lpc_evt(lpc_evt), .acpi_evt(acpi_evt),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
    .l2_sel(l2_sel), .l2_wr(l2_wr), .l2_wdata(l2_wdata), .l2_rdata(l2_rdata),
    .smi_req(smi_req)
  );

  // monitor: pops expected items and compares with the live outputs
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      begin
        exp_t        it;
        logic [15:0] act;
        it = exp_q.pop_front();
        case (it.kind)
          0:       act = stat_rdata;
          1:       act = {15'd0, smi_req};
          2:       act = l2_rdata;
          default: act = stat_rdata & 16'hE013;
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input int kind, input logic [1:0] sel, input logic [15:0] exp, input string tag);
    exp_t it;
    l2_sel = sel;
    it.kind = kind; it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
  endtask

  // order: nmi, sio, sw, a20, vtmr, vrtr
  task automatic fire(input logic [5:0] v);
    {nmi_evt, sio_irq_evt, sw_evt, a20_evt, vtmr_evt, vrtr_evt} = v;
    tick();
    {nmi_evt, sio_irq_evt, sw_evt, a20_evt, vtmr_evt, vrtr_evt} = '0;
  endtask

  task automatic rd_status();
    stat_rd = 1; tick(); stat_rd = 0;
  endtask

  task automatic l2_clear(input logic [1:0] sel, input logic [15:0] m);
    l2_sel = sel; l2_wdata = m; l2_wr = 1; tick(); l2_wr = 0; l2_wdata = '0;
  endtask

  task automatic set_en(input logic [2:0] e);
    cfg_wdata = e; cfg_wr = 1; tick(); cfg_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1 reset state
    chk(0, 2'd0, 16'h0000, "R1 status after reset");
    chk(1, 2'd0, 16'h0000, "R1 smi_req after reset");
    for (int s = 0; s < 4; s++) chk(2, s[1:0], 16'h0000, "R1 second-level after reset");

    // R4 / R1: enables are zero after reset, gated sources ignored
    fire(6'b000111);
    chk(0, 2'd0, 16'h0000, "R4 gated sources ignored while disabled");
    tick();
    chk(1, 2'd0, 16'h0000, "R4 no request from disabled sources");

    set_en(3'b111);

    // R2 / R9 single source
    fire(6'b100000);
    chk(0, 2'd0, 16'h1000, "R2 NMI bit set");
    tick();
    chk(1, 2'd0, 16'h0001, "R9 request raised");
    stat_rd = 1;
    chk(0, 2'd0, 16'h1000, "R2 read returns set bit");
    tick(); stat_rd = 0;
    chk(0, 2'd0, 16'h0000, "R2 cleared by read");
    chk(1, 2'd0, 16'h0001, "R9 request lags by one cycle");
    tick();
    chk(1, 2'd0, 16'h0000, "R9 request drops");

    // R2 all latched sources
    fire(6'b111111);
    chk(0, 2'd0, 16'h19E0, "R2 all clear-on-read bits");
    rd_status();
    chk(0, 2'd0, 16'h0000, "R2 all cleared");

    // R3 event during read
    fire(6'b100000);
    stat_rd = 1; sw_evt = 1;
    chk(0, 2'd0, 16'h1000, "R3 read returns old value");
    tick(); stat_rd = 0; sw_evt = 0;
    chk(0, 2'd0, 16'h0100, "R3 new event kept, old cleared");
    stat_rd = 1; sw_evt = 1;
    tick(); stat_rd = 0; sw_evt = 0;
    chk(0, 2'd0, 16'h0100, "R3 same-bit event during read kept");
    rd_status();

    // R4 selective enable
    set_en(3'b110);
    fire(6'b000100);
    chk(0, 2'd0, 16'h0000, "R4 A20 disabled");
    fire(6'b000010);
    chk(0, 2'd0, 16'h0040, "R4 video timer enabled");
    set_en(3'b011);
    fire(6'b000001);
    chk(0, 2'd0, 16'h0040, "R4 retrace disabled");
    rd_status();
    tick();

    // R5 external falling edge
    ext_smi_n[3] = 1'b0;
    tick(); tick(); tick();
    chk(2, 2'd0, 16'h0008, "R5 falling edge latched");
    chk(0, 2'd0, 16'h0000, "R6 summary lags one cycle");
    tick();
    chk(0, 2'd0, 16'h0400, "R6 external summary set");
    rd_status();
    chk(0, 2'd0, 16'h0400, "R6 summary survives read");
    l2_clear(2'd0, 16'h0008);
    repeat (4) tick();
    chk(2, 2'd0, 16'h0000, "R5 held-low level does not re-set");
    ext_smi_n[3] = 1'b1;
    repeat (4) tick();
    chk(2, 2'd0, 16'h0000, "R5 rising edge ignored");
    tick();
    chk(1, 2'd0, 16'h0000, "R9 request off after clear");

    // R7 / R10 timer-trap register
    trap_evt = 8'h81; tick(); trap_evt = '0;
    chk(2, 2'd1, 16'h0081, "R6 trap second-level");
    tick();
    chk(0, 2'd0, 16'h0200, "R6 trap summary");
    l2_clear(2'd1, 16'h0000);
    chk(2, 2'd1, 16'h0081, "R7 zero mask leaves bits");
    l2_clear(2'd1, 16'h0001);
    chk(2, 2'd1, 16'h0080, "R7 partial clear");
    chk(0, 2'd0, 16'h0200, "R7 summary holds while bits remain");
    trap_evt = 8'h01;
    l2_clear(2'd1, 16'h0081);
    trap_evt = '0;
    chk(2, 2'd1, 16'h0001, "R10 event wins over clear");
    l2_clear(2'd1, 16'h0001);
    chk(0, 2'd0, 16'h0200, "R7 summary one cycle after last clear");
    tick();
    chk(0, 2'd0, 16'h0000, "R7 summary dropped");

    // R6 / R8 everything at once
    {nmi_evt, sio_irq_evt, sw_evt, a20_evt, vtmr_evt, vrtr_evt} = 6'b111111;
    set_en(3'b111);
    ext_smi_n = 8'h00; trap_evt = 8'hFF; lpc_evt = 2'b10; acpi_evt = 8'h40;
    {nmi_evt, sio_irq_evt, sw_evt, a20_evt, vtmr_evt, vrtr_evt} = 6'b111111;
    tick();
    {nmi_evt, sio_irq_evt, sw_evt, a20_evt, vtmr_evt, vrtr_evt} = '0;
    trap_evt = '0; lpc_evt = '0; acpi_evt = '0;
    chk(2, 2'd2, 16'h0002, "R6 LPC second-level");
    chk(2, 2'd3, 16'h0040, "R6 ACPI second-level");
    repeat (5) tick();
    chk(0, 2'd0, 16'h1FEC, "R6 all sources in status word");
    chk(4, 2'd0, 16'h0000, "R8 reserved bits zero");
    rd_status();
    chk(0, 2'd0, 16'h060C, "R6 summaries remain after read");
    chk(1, 2'd0, 16'h0001, "R9 request still high");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule